// File: doc/BRIEF.md
# Gapped Serial Line Timing Controller

This block generates the two timing strobes that the clock-supplying end of a synchronous serial link drives toward its partner. One strobe paces the receive direction, where the block shifts data out one bit per pulse. The other paces the transmit direction, where the block samples the incoming bit once per pulse. Both strobes come from a fast system clock and a one-cycle bit-rate tick. The fast clock must run at no less than four times the bit rate. Each direction can be stopped ("gapped") and restarted on its own. On each bit tick, a direction's state machine picks one of three things: issue a data pulse, issue a hold-off pulse, or stay silent.

Each direction has three states. IDLE means gapped: the strobe is held low. STREAM means every tick issues a data pulse. HOLDOFF means trailing pulses are being counted down after the bit flagged as last. The transitions are:
- IDLE to STREAM, when the request is high at a tick and the last flag is low.
- IDLE or STREAM to HOLDOFF, when a data pulse is issued with the last flag high.
- HOLDOFF to STREAM, when the request is high at a tick. This cancels the countdown.
- HOLDOFF to HOLDOFF, when a hold-off pulse is issued and the counter is decremented.
- HOLDOFF to IDLE, when a tick finds the counter at zero and the request low.

The receive direction counts 23 trailing pulses and the transmit direction counts 1. Data changes on the rising (leading) edge of a pulse and is sampled on its falling (trailing) edge.

Top module: `gapped_clk_ctrl`

## Requirements
- R1: After reset both timing outputs, `rx_dat_o`, `tx_cap_bit` and `tx_cap_vld` are 0. Both directions are in IDLE with their counters at zero.
- R2: A pulse begins only at the clock edge that samples `bit_tick` high. It stays high for exactly `HI_CYC` system clocks, then stays low at least until the next tick, so no shortened pulse is ever produced.
- R3: A direction in IDLE whose request is low at a tick emits no pulse, and its last flag at that tick has no effect.
- R4: On each receive data pulse, `rx_src_take` is high in the tick cycle. `rx_dat_o` takes `rx_src_bit` at the same edge at which `rx_tmg_o` rises.
- R5: On each transmit data pulse, `tx_cap_bit` takes `tx_dat_i` at the edge where `tx_tmg_o` falls, and `tx_cap_vld` is high for exactly the following cycle.
- R6: After the receive data pulse flagged last, with the request low, exactly 23 further receive pulses are emitted and then `rx_tmg_o` stops.
- R7: After the transmit data pulse flagged last, with the request low, exactly 1 further transmit pulse is emitted and then `tx_tmg_o` stops.
- R8: A request that is high at a tick during hold-off cancels the countdown. Pulses continue at every tick with no gap, and they become data pulses again.
- R9: Hold-off pulses carry no data. `rx_src_take` and `tx_cap_vld` stay low for them, and `rx_dat_o` keeps its value.
- R10: While a direction is gapped, its timing output is low and its data output holds the last value it took.
- R11: The two directions are independent. Requests, last flags and hold-off in one direction never change the pulses of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary |
| rx_req | input | 1 | Receive-direction run request, level |
| rx_lastbit | input | 1 | Marks the receive bit issued at this tick as the final one |
| rx_src_bit | input | 1 | Next bit from the parallel-to-serial source |
| rx_src_take | output | 1 | Source bit consumed this cycle |
| rx_tmg_o | output | 1 | Receive timing strobe |
| rx_dat_o | output | 1 | Receive data line |
| tx_req | input | 1 | Transmit-direction run request, level |
| tx_lastbit | input | 1 | Marks the transmit bit issued at this tick as the final one |
| tx_dat_i | input | 1 | Transmit data line from the partner |
| tx_tmg_o | output | 1 | Transmit timing strobe |
| tx_cap_bit | output | 1 | Most recently captured transmit bit |
| tx_cap_vld | output | 1 | One-cycle strobe after each capture |

## Verification
The embedded checks assume that consecutive `bit_tick` pulses are at least `2*HI_CYC` system clocks apart, so a strobe is always low again before the next boundary. They also assume that the last flags are acted on only in tick cycles. The stimulus issues a tick every fourth clock with `HI_CYC` of 2, and it raises each last flag only during a tick cycle. Requests are changed only on the falling clock edge and held for a whole bit period. This keeps every request decision aligned to a bit boundary, as the state machines expect.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_STREAM  = 2'd1,
        CH_HOLDOFF = 2'd2
    } ch_state_t;
endpackage

// File: rtl/gcc_pulse_gen.sv
module gcc_pulse_gen #(
    parameter int HI_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic data,
    output logic tmg,
    output logic sample
);
    localparam int HW = (HI_CYC > 1) ? $clog2(HI_CYC) : 1;

    logic [HW-1:0] hcnt;
    logic          is_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmg     <= 1'b0;
            hcnt    <= '0;
            is_data <= 1'b0;
        end else if (go) begin
            tmg     <= 1'b1;
            hcnt    <= HW'(HI_CYC - 1);
            is_data <= data;
        end else if (tmg) begin
            if (hcnt == '0) tmg <= 1'b0;
            else            hcnt <= hcnt - 1'b1;
        end
    end

    // trailing edge of a data-carrying pulse happens at this edge
    assign sample = tmg && (hcnt == '0) && is_data;

    // R2
    rise_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmg) |-> $past(go));
    // R2
    go_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !tmg);
endmodule

// File: rtl/gcc_chan.sv
module gcc_chan
    import gcc_pkg::*;
#(
    parameter int HOLD   = 23,
    parameter int HI_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    input  logic last,
    output logic tmg,
    output logic launch,
    output logic sample
);
    localparam int CW = (HOLD > 0) ? $clog2(HOLD + 1) : 1;

    ch_state_t     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        launch  = 1'b0;
        go      = 1'b0;
        unique case (state)
            CH_IDLE:    if (tick && req) launch = 1'b1;
            CH_STREAM:  if (tick) launch = 1'b1;
            CH_HOLDOFF: if (tick) begin
                if (req) begin
                    launch = 1'b1;
                end else if (cnt != '0) begin
                    go      = 1'b1;
                    cnt_nxt = cnt - 1'b1;
                end else begin
                    nxt = CH_IDLE;
                end
            end
            default:    nxt = CH_IDLE;
        endcase
        if (launch) begin
            go      = 1'b1;
            nxt     = last ? CH_HOLDOFF : CH_STREAM;
            cnt_nxt = last ? CW'(HOLD) : '0;
        end
    end

    gcc_pulse_gen #(.HI_CYC(HI_CYC)) u_pg (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .data   (launch),
        .tmg    (tmg),
        .sample (sample)
    );

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));
    // R1
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/gapped_clk_ctrl.sv
module gapped_clk_ctrl #(
    parameter int RX_HOLD = 23,
    parameter int TX_HOLD = 1,
    parameter int HI_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_req,
    input  logic rx_lastbit,
    input  logic rx_src_bit,
    output logic rx_src_take,
    output logic rx_tmg_o,
    output logic rx_dat_o,
    input  logic tx_req,
    input  logic tx_lastbit,
    input  logic tx_dat_i,
    output logic tx_tmg_o,
    output logic tx_cap_bit,
    output logic tx_cap_vld
);
    logic rx_launch, rx_sample_unused;
    logic tx_launch_unused, tx_sample;

    gcc_chan #(.HOLD(RX_HOLD), .HI_CYC(HI_CYC)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .req    (rx_req),
        .last   (rx_lastbit),
        .tmg    (rx_tmg_o),
        .launch (rx_launch),
        .sample (rx_sample_unused)
    );

    gcc_chan #(.HOLD(TX_HOLD), .HI_CYC(HI_CYC)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .req    (tx_req),
        .last   (tx_lastbit),
        .tmg    (tx_tmg_o),
        .launch (tx_launch_unused),
        .sample (tx_sample)
    );

    assign rx_src_take = rx_launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_dat_o   <= 1'b0;
            tx_cap_bit <= 1'b0;
            tx_cap_vld <= 1'b0;
        end else begin
            if (rx_launch) rx_dat_o <= rx_src_bit;
            if (tx_sample) tx_cap_bit <= tx_dat_i;
            tx_cap_vld <= tx_sample;
        end
    end

    // R4
    take_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_src_take |=> (rx_tmg_o && (rx_dat_o == $past(rx_src_bit))));
    // R5
    cap_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cap_vld |-> !tx_tmg_o);
endmodule

// File: tb/sim_gapped_clk_ctrl.sv
module sim_gapped_clk_ctrl;
    localparam int RXH = 23, TXH = 1, HI = 2, TPER = 4;

    logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
    logic rx_req = 1'b0, rx_lastbit = 1'b0, rx_src_bit = 1'b0;
    logic tx_req = 1'b0, tx_lastbit = 1'b0, tx_dat_i = 1'b0;
    logic rx_src_take, rx_tmg_o, rx_dat_o, tx_tmg_o, tx_cap_bit, tx_cap_vld;

    always #5 clk = ~clk;

    gapped_clk_ctrl #(.RX_HOLD(RXH), .TX_HOLD(TXH), .HI_CYC(HI)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    logic [15:0] lf = 16'hACE1;
    bit done = 0;

    // behavioural reference: mode 0 gapped, 1 streaming, 2 trailing
    int  m_mode[2], m_hold[2], m_hi[2];
    bit  m_tmg[2], m_dat[2];
    bit  e_rxdat, e_capbit, e_capvld;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_mode[c] = 0; m_hold[c] = 0; m_hi[c] = 0; m_tmg[c] = 0; m_dat[c] = 0;
            end
            e_rxdat = 0; e_capbit = 0; e_capvld = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit rq, ls, fall, start;
                rq = c ? tx_req : rx_req;
                ls = c ? tx_lastbit : rx_lastbit;
                fall = m_tmg[c] && (m_hi[c] == 0);
                if (c == 1) begin
                    e_capvld = fall && m_dat[1];
                    if (e_capvld) e_capbit = tx_dat_i;
                end
                if (m_tmg[c]) begin
                    if (m_hi[c] == 0) m_tmg[c] = 0; else m_hi[c]--;
                end
                if (bit_tick) begin
                    start = (m_mode[c] == 1) || rq;
                    if (start) begin
                        m_tmg[c] = 1; m_hi[c] = HI - 1; m_dat[c] = 1;
                        if (c == 0) e_rxdat = rx_src_bit;
                        m_mode[c] = ls ? 2 : 1;
                        m_hold[c] = ls ? (c ? TXH : RXH) : 0;
                    end else if (m_mode[c] == 2) begin
                        if (m_hold[c] > 0) begin
                            m_hold[c]--; m_tmg[c] = 1; m_hi[c] = HI - 1; m_dat[c] = 0;
                        end else m_mode[c] = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int  rx_rises = 0, tx_rises = 0, takes = 0, caps = 0, phase = 0;
    bit  prev_rx = 0, prev_tx = 0, last_taken = 0;

    task automatic step(input bit rq, input bit rl, input bit tq, input bit tl);
        bit exp_take;
        @(negedge clk);
        bit_tick   = (phase == 0);
        rx_req     = rq;
        tx_req     = tq;
        rx_lastbit = rl && (phase == 0);
        tx_lastbit = tl && (phase == 0);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rx_src_bit = lf[0];
        tx_dat_i   = lf[5];
        phase = (phase + 1) % TPER;
        #1;
        exp_take = bit_tick && ((m_mode[0] == 1) || rx_req);
        chk("R2 R6 R8 rx_tmg_o", rx_tmg_o, m_tmg[0]);
        chk("R2 R7 R11 tx_tmg_o", tx_tmg_o, m_tmg[1]);
        chk("R4 R9 R10 rx_dat_o", rx_dat_o, e_rxdat);
        chk("R4 R9 rx_src_take", rx_src_take, exp_take);
        chk("R5 tx_cap_bit", tx_cap_bit, e_capbit);
        chk("R5 R9 tx_cap_vld", tx_cap_vld, e_capvld);
        if (rx_tmg_o && !prev_rx) rx_rises++;
        if (tx_tmg_o && !prev_tx) tx_rises++;
        if (rx_src_take) begin takes++; last_taken = rx_src_bit; end
        if (tx_cap_vld) caps++;
        prev_rx = rx_tmg_o;
        prev_tx = tx_tmg_o;
    endtask

    task automatic period(input bit rq, input bit rl, input bit tq, input bit tl);
        for (int i = 0; i < TPER; i++) step(rq, rl, tq, tl);
    endtask

    task automatic clr();
        rx_rises = 0; tx_rises = 0; takes = 0; caps = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 rx_tmg_o", rx_tmg_o, 1'b0);
        chk("R1 tx_tmg_o", tx_tmg_o, 1'b0);
        chk("R1 rx_dat_o", rx_dat_o, 1'b0);
        chk("R1 tx_cap_vld", tx_cap_vld, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R3: no request, last flags high at ticks, nothing happens
        clr();
        for (int i = 0; i < 4; i++) period(0, 1, 0, 1);
        chk_int("R3 rx pulses while idle", rx_rises, 0);
        chk_int("R3 tx pulses while idle", tx_rises, 0);

        // R6 R7 R9: bursts on both, last on the fourth bit
        for (int i = 0; i < 3; i++) period(1, 0, 1, 0);
        clr();
        period(1, 1, 1, 1);
        for (int i = 0; i < 30; i++) period(0, 0, 0, 0);
        chk_int("R6 rx pulses incl. last", rx_rises, 1 + RXH);
        chk_int("R7 tx pulses incl. last", tx_rises, 1 + TXH);
        chk_int("R9 takes in hold-off", takes, 1);
        chk_int("R9 captures in hold-off", caps, 1);

        // R10: gapped, outputs held
        clr();
        for (int i = 0; i < 5; i++) period(0, 0, 0, 0);
        chk_int("R10 rx pulses while gapped", rx_rises, 0);
        chk("R10 rx_tmg_o low", rx_tmg_o, 1'b0);
        chk("R10 rx_dat_o held", rx_dat_o, last_taken);

        // R8: request during hold-off cancels countdown
        clr();
        period(1, 1, 0, 0);
        for (int i = 0; i < 4; i++) period(0, 0, 0, 0);
        period(1, 0, 0, 0);
        period(1, 1, 0, 0);
        for (int i = 0; i < 30; i++) period(0, 0, 0, 0);
        chk_int("R8 rx pulses with cancel", rx_rises, 1 + 4 + 1 + 1 + RXH);
        chk_int("R8 data pulses with cancel", takes, 3);

        // R11: transmit burst alone leaves receive silent
        clr();
        period(0, 0, 1, 0);
        period(0, 0, 1, 1);
        for (int i = 0; i < 4; i++) period(0, 0, 0, 0);
        chk_int("R11 rx silent", rx_rises, 0);
        chk_int("R11 tx pulses", tx_rises, 2 + TXH);
        chk_int("R5 tx captures", caps, 2);

        done = 1;
        summary();
        $finish;
    end
endmodule